// File: doc/BRIEF.md
# Two-Stage Fetch/Execute Sequencer

This block is the instruction front end of a small 8-bit controller core that uses 14-bit instruction words. One machine cycle is four input clocks, called phases Q1 to Q4. While one instruction executes, the next word is fetched, so the sequencer completes one instruction per machine cycle. The fetch address and the instruction register change only at the end of Q1. A data-memory read strobe is raised in Q2 and a write strobe in Q4.

A jump, a subroutine call or a return changes the fetch address. The word that was prefetched behind that instruction is then discarded, and the next machine cycle executes it as a forced no-operation. Calls push their return address onto an eight-entry circular stack, and returns pop it. When more than eight calls are nested, the oldest entry is overwritten without any notice.

Decode is deliberately minimal. It recognises no-operation, jump, call and return. Every other word is a generic ALU or move operation that reads a data address and can write it back.

Top module: `fx_seq`

## Requirements
- R1: The phase output counts 0,1,2,3 (Q1,Q2,Q3,Q4) and then repeats, one step per clock. Reset holds the phase at 1 (Q2) of the first fetch cycle.
- R2: During reset and just after it, `pmem_addr` is 0, `exec_ir` is 0 (no-operation) and `flush_nop` is low. The first fetched word executes one machine cycle later.
- R3: `pmem_addr` and `exec_ir` change only on the clock edge that ends Q1. On that edge, in sequential flow, `exec_ir` takes the word returned for the previous fetch address and `pmem_addr` advances by one, wrapping in 11 bits.
- R4: `dmem_rd` is high only in Q2, and only when `exec_ir` is an ALU-class word. `dmem_addr` is `exec_ir[6:0]`.
- R5: `dmem_wr` is high only in Q4, and only when `exec_ir` is an ALU-class word with bit 7 set.
- R6: A jump has `exec_ir[13:11]` = 3'b101 and its target in `[10:0]`. At the end of its Q1 that follows execution, `pmem_addr` becomes the target and the next machine cycle executes a forced no-operation.
- R7: A call has `exec_ir[13:11]` = 3'b100. It pushes the address that follows the call and then redirects to `[10:0]` in the same way as a jump.
- R8: A return is the word 14'h0008. It pops the stack, redirects to the popped address and costs one forced no-operation cycle.
- R9: The stack holds 8 entries and wraps in a circle. The ninth nested push overwrites the oldest entry, and later pops keep cycling through the eight slots. The slots are zero after reset.
- R10: The word 14'h0000 is a no-operation and raises neither data strobe. Any word that is not a no-operation, jump, call or return belongs to the ALU class.
- R11: `flush_nop` is high for exactly the machine cycle that executes a discarded prefetch. During that cycle `exec_ir` is 0 and no data strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| pmem_data | input | 14 | Word returned by synchronous program memory |
| pmem_addr | output | 11 | Program fetch address |
| seq_phase | output | 2 | Current phase, 0 to 3 for Q1 to Q4 |
| exec_ir | output | 14 | Instruction register (word being executed) |
| flush_nop | output | 1 | Current execute slot is a forced no-operation |
| dmem_addr | output | 7 | Data operand address |
| dmem_rd | output | 1 | Operand read strobe (Q2) |
| dmem_wr | output | 1 | Destination write strobe (Q4) |

## Verification
A directed program runs first. It contains a write-back ALU word, a read-only ALU word, a call/return pair and a jump, which separates sequential flow from each kind of redirect. It then nests nine calls and follows them with an unbounded chain of returns. A stack that saturates or refuses the ninth push ends up at a different address from one that wraps. A seeded random program comes second and mixes all word classes, including returns from an empty stack and calls nested deeper than eight. In that program, back-to-back redirects and a branch placed directly after a flush show whether the discarded word is ever executed.

// File: rtl/fx_seq_pkg.sv
package fx_seq_pkg;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_ALU,
        OP_GOTO,
        OP_CALL,
        OP_RET
    } op_e;

    typedef enum logic {
        SL_RUN,
        SL_REDIRECT
    } slot_e;

    localparam logic [2:0] TAG_GOTO = 3'b101;
    localparam logic [2:0] TAG_CALL = 3'b100;
    localparam int unsigned RET_CODE = 8;

endpackage

// File: rtl/fx_phase_gen.sv
module fx_phase_gen
    import fx_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase
);

    phase_e state_q;
    phase_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_Q2;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_Q1: state_d = PH_Q2;
            PH_Q2: state_d = PH_Q3;
            PH_Q3: state_d = PH_Q4;
            PH_Q4: state_d = PH_Q1;
            default: state_d = PH_Q1;
        endcase
    end

    assign phase = state_q;

endmodule

// File: rtl/fx_decode.sv
module fx_decode
    import fx_seq_pkg::*;
#(
    parameter int IW   = 14,
    parameter int PC_W = 11,
    parameter int DA_W = 7
) (
    input  logic [IW-1:0]   ir,
    output op_e             op,
    output logic [PC_W-1:0] target,
    output logic [DA_W-1:0] daddr,
    output logic            wr_dest
);

    localparam logic [IW-1:0] RET_WORD = IW'(RET_CODE);

    logic [2:0] tag;
    assign tag = ir[IW-1 -: 3];

    always_comb begin
        if (ir == '0) begin
            op = OP_NOP;
        end else if (ir == RET_WORD) begin
            op = OP_RET;
        end else if (tag == TAG_GOTO) begin
            op = OP_GOTO;
        end else if (tag == TAG_CALL) begin
            op = OP_CALL;
        end else begin
            op = OP_ALU;
        end
    end

    assign target  = ir[PC_W-1:0];
    assign daddr   = ir[DA_W-1:0];
    assign wr_dest = ir[DA_W];

endmodule

// File: rtl/fx_ret_stack.sv
module fx_ret_stack #(
    parameter int DEPTH = 8,
    parameter int AW    = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_addr,
    output logic [AW-1:0] top_addr
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] slot_q [DEPTH];
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_dec;

    assign ptr_dec  = (ptr_q == '0) ? PW'(DEPTH - 1) : ptr_q - 1'b1;
    assign top_addr = slot_q[ptr_dec];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (push) begin
            ptr_q <= (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
        end else if (pop) begin
            ptr_q <= ptr_dec;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (push && (ptr_q == PW'(g))) begin
                slot_q[g] <= push_addr;
            end
        end
    end

endmodule

// File: rtl/fx_seq.sv
module fx_seq
    import fx_seq_pkg::*;
#(
    parameter int IW        = 14,
    parameter int PC_W      = 11,
    parameter int DA_W      = 7,
    parameter int STK_DEPTH = 8,
    parameter int STK_W     = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   pmem_data,
    output logic [PC_W-1:0] pmem_addr,
    output logic [1:0]      seq_phase,
    output logic [IW-1:0]   exec_ir,
    output logic            flush_nop,
    output logic [DA_W-1:0] dmem_addr,
    output logic            dmem_rd,
    output logic            dmem_wr
);

    phase_e          phase;
    op_e             op;
    logic [PC_W-1:0] br_target;
    logic            wr_dest;
    logic [STK_W-1:0] stk_top;
    logic            do_push;
    logic            do_pop;
    logic            is_branch;

    slot_e           slot_q;
    logic [PC_W-1:0] fetch_pc_q;
    logic [PC_W-1:0] redirect_pc_q;
    logic [IW-1:0]   ir_q;
    logic            flush_q;

    fx_phase_gen u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    fx_decode #(
        .IW   (IW),
        .PC_W (PC_W),
        .DA_W (DA_W)
    ) u_dec (
        .ir      (ir_q),
        .op      (op),
        .target  (br_target),
        .daddr   (dmem_addr),
        .wr_dest (wr_dest)
    );

    assign is_branch = (op == OP_GOTO) || (op == OP_CALL) || (op == OP_RET);
    assign do_push   = (phase == PH_Q4) && (op == OP_CALL);
    assign do_pop    = (phase == PH_Q4) && (op == OP_RET);

    fx_ret_stack #(
        .DEPTH (STK_DEPTH),
        .AW    (STK_W)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pop       (do_pop),
        .push_addr (STK_W'(fetch_pc_q)),
        .top_addr  (stk_top)
    );

    // Slot state: a redirect is decided in Q4 and applied at the end of Q1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q        <= SL_RUN;
            redirect_pc_q <= '0;
        end else begin
            unique case (slot_q)
                SL_RUN: begin
                    if (phase == PH_Q4 && is_branch) begin
                        slot_q        <= SL_REDIRECT;
                        redirect_pc_q <= (op == OP_RET) ? stk_top[PC_W-1:0] : br_target;
                    end
                end
                SL_REDIRECT: begin
                    if (phase == PH_Q1) begin
                        slot_q <= SL_RUN;
                    end
                end
                default: slot_q <= SL_RUN;
            endcase
        end
    end

    // Fetch address and instruction register, both updated at the end of Q1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fetch_pc_q <= '0;
            ir_q       <= '0;
            flush_q    <= 1'b0;
        end else if (phase == PH_Q1) begin
            if (slot_q == SL_REDIRECT) begin
                fetch_pc_q <= redirect_pc_q;
                ir_q       <= '0;
                flush_q    <= 1'b1;
            end else begin
                fetch_pc_q <= fetch_pc_q + 1'b1;
                ir_q       <= pmem_data;
                flush_q    <= 1'b0;
            end
        end
    end

    // Output process: phase-qualified strobes.
    always_comb begin
        dmem_rd = 1'b0;
        dmem_wr = 1'b0;
        unique case (phase)
            PH_Q1: ;
            PH_Q2: dmem_rd = (op == OP_ALU);
            PH_Q3: ;
            PH_Q4: dmem_wr = (op == OP_ALU) && wr_dest;
            default: ;
        endcase
    end

    assign pmem_addr = fetch_pc_q;
    assign seq_phase = phase;
    assign exec_ir   = ir_q;
    assign flush_nop = flush_q;

endmodule

// File: rtl/fx_seq_checker.sv
module fx_seq_checker #(
    parameter int IW   = 14,
    parameter int PC_W = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] pmem_addr,
    input logic [1:0]      seq_phase,
    input logic [IW-1:0]   exec_ir,
    input logic            flush_nop,
    input logic            dmem_rd,
    input logic            dmem_wr
);

    p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (seq_phase == 2'($past(seq_phase) + 2'd1)));

    p_fetch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_phase != 2'd0) |=> ($stable(pmem_addr) && $stable(exec_ir)));

    p_read_in_q2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd |-> (seq_phase == 2'd1));

    p_write_in_q4_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_wr |-> (seq_phase == 2'd3));

    p_goto_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_phase == 2'd0 && exec_ir[IW-1 -: 3] == 3'b101)
        |=> (pmem_addr == $past(exec_ir[PC_W-1:0]) && flush_nop));

    p_nop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_ir == '0) |-> (!dmem_rd && !dmem_wr));

    p_flush_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_nop |-> (exec_ir == '0 && !dmem_rd && !dmem_wr));

endmodule

bind fx_seq fx_seq_checker #(.IW(IW), .PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pmem_addr (pmem_addr),
    .seq_phase (seq_phase),
    .exec_ir   (exec_ir),
    .flush_nop (flush_nop),
    .dmem_rd   (dmem_rd),
    .dmem_wr   (dmem_wr)
);

// File: tb/fx_seq_test.sv
module fx_seq_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] pmem_data = '0;
    logic [10:0] pmem_addr;
    logic [1:0]  seq_phase;
    logic [13:0] exec_ir;
    logic        flush_nop;
    logic [6:0]  dmem_addr;
    logic        dmem_rd;
    logic        dmem_wr;

    int tests = 0;
    int fails = 0;

    logic [13:0] mem [2048];

    // model state
    logic [10:0] m_fa;
    logic [13:0] m_ir;
    logic        m_flush;
    logic [12:0] m_stk [8];
    logic [2:0]  m_ptr;
    int          m_pushes;
    string       m_tag;

    fx_seq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pmem_data (pmem_data),
        .pmem_addr (pmem_addr),
        .seq_phase (seq_phase),
        .exec_ir   (exec_ir),
        .flush_nop (flush_nop),
        .dmem_addr (dmem_addr),
        .dmem_rd   (dmem_rd),
        .dmem_wr   (dmem_wr)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) pmem_data <= mem[pmem_addr];

    // kinds: 0 nop, 1 alu, 2 goto, 3 call, 4 return
    function automatic int kind_of(logic [13:0] w);
        if (w == 14'h0000) return 0;
        if (w == 14'h0008) return 4;
        if (w[13:11] == 3'b101) return 2;
        if (w[13:11] == 3'b100) return 3;
        return 1;
    endfunction

    function automatic logic [13:0] rand_word();
        int unsigned r;
        r = $urandom_range(99);
        if (r < 8)  return 14'h0000;
        if (r < 16) return {3'b101, 11'($urandom)};
        if (r < 23) return {3'b100, 11'($urandom)};
        if (r < 30) return 14'h0008;
        return {1'b0, 13'($urandom)} | 14'h0010;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R2", "pmem_addr in reset", int'(pmem_addr), 0);
        check("R2", "exec_ir in reset", int'(exec_ir), 0);
        check("R2", "flush in reset", int'(flush_nop), 0);
        check("R1", "phase in reset", int'(seq_phase), 1);
        rst_n = 1'b1;
        m_fa = '0; m_ir = '0; m_flush = 1'b0; m_ptr = '0; m_pushes = 0; m_tag = "R2";
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
    endtask

    // Entered at the negedge inside Q2; leaves at the negedge inside the next Q2.
    task automatic run_cycle();
        int k;
        bit alu;
        k = kind_of(m_ir);
        alu = (k == 1);
        check("R1", "phase Q2", int'(seq_phase), 1);
        check(m_tag, "fetch addr", int'(pmem_addr), int'(m_fa));
        check(m_tag, "exec_ir", int'(exec_ir), int'(m_ir));
        check("R11", "flush_nop", int'(flush_nop), int'(m_flush));
        check(k == 0 ? "R10" : "R4", "dmem_rd Q2", int'(dmem_rd), int'(alu));
        if (alu) check("R4", "dmem_addr", int'(dmem_addr), int'(m_ir[6:0]));
        check("R5", "dmem_wr Q2", int'(dmem_wr), 0);
        @(negedge clk);
        check("R1", "phase Q3", int'(seq_phase), 2);
        check("R4", "dmem_rd Q3", int'(dmem_rd), 0);
        check("R5", "dmem_wr Q3", int'(dmem_wr), 0);
        @(negedge clk);
        check("R1", "phase Q4", int'(seq_phase), 3);
        check("R3", "fetch addr held Q4", int'(pmem_addr), int'(m_fa));
        check("R4", "dmem_rd Q4", int'(dmem_rd), 0);
        check(k == 0 ? "R10" : "R5", "dmem_wr Q4", int'(dmem_wr), int'(alu && m_ir[7]));
        @(negedge clk);
        check("R1", "phase Q1", int'(seq_phase), 0);
        check("R3", "exec_ir held Q1", int'(exec_ir), int'(m_ir));
        check("R4", "dmem_rd Q1", int'(dmem_rd), 0);
        // advance model at the end of Q1
        case (k)
            2: begin m_tag = "R6"; m_fa = m_ir[10:0]; m_ir = '0; m_flush = 1'b1; end
            3: begin
                m_stk[m_ptr] = {2'b00, m_fa};
                m_ptr = m_ptr + 3'd1;
                m_pushes++;
                m_tag = "R7"; m_fa = m_ir[10:0]; m_ir = '0; m_flush = 1'b1;
            end
            4: begin
                m_ptr = m_ptr - 3'd1;
                m_tag = (m_pushes > 8) ? "R9" : "R8";
                m_fa = m_stk[m_ptr][10:0]; m_ir = '0; m_flush = 1'b1;
            end
            default: begin
                m_tag = "R3"; m_ir = mem[m_fa]; m_fa = m_fa + 11'd1; m_flush = 1'b0;
            end
        endcase
        @(negedge clk);
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // directed program
        for (int i = 0; i < 2048; i++) mem[i] = 14'h0000;
        mem[0]     = 14'h0785;                 // ALU, write-back, addr 5
        mem[1]     = {3'b100, 11'h010};        // call 0x010
        mem[2]     = {3'b101, 11'h040};        // jump 0x040
        mem[11'h010] = 14'h3023;               // ALU, read only
        mem[11'h011] = 14'h0008;               // return
        for (int k = 0; k < 9; k++) begin
            mem[11'h040 + 2*k] = {3'b100, 11'(11'h042 + 2*k)};
            mem[11'h041 + 2*k] = 14'h0008;
        end
        mem[11'h052] = 14'h0008;
        do_reset();
        for (int c = 0; c < 80; c++) run_cycle();

        // random program
        for (int i = 0; i < 2048; i++) mem[i] = rand_word();
        do_reset();
        for (int c = 0; c < 3000; c++) run_cycle();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule